// File: doc/BRIEF.md
# Byte-indexed table lookup unit

This unit assembles a 64-bit word from eight byte lanes. Each lane carries its own 8-bit index into a small byte table. The table is formed from one to four 64-bit table words, and all of them arrive together on a 256-bit input. A 2-bit length code in the descriptor sets how many of those bytes count as valid table contents. When a lane's index lies outside that length, the lane keeps the byte in the same position of a separate 64-bit fallback operand.

A caller presents the descriptor, table, index vector and fallback vector with `in_valid` high for one cycle. The block captures them on that edge. One cycle later it raises `out_valid` with the finished word. All eight lanes work in parallel, and no lane depends on any other. The descriptor bits above the length code are meant for the stage that gathers the table words. This block ignores them.

Top module: `tbl_lookup_unit`

## Requirements
- R1: The length code `in_desc[1:0]` = n sets the table length to (n+1)*8 bytes, giving 8, 16, 24 or 32.
- R2: Lane k takes its index from `in_index[8k+7:8k]` and drives `out_result[8k+7:8k]`, for k = 0..7.
- R3: An index counts as inside the table only when it is strictly less than the table length in bytes. An index equal to the length is outside the table.
- R4: For an index inside the table, bits [7:3] pick the table word and bits [2:0] pick the byte in that word, with byte 0 the least significant. Table word w occupies `in_table[64w+63:64w]`.
- R5: For an index outside the table, the lane outputs `in_default[8k+7:8k]`.
- R6: The descriptor bits above bit 1 have no effect on the result.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_result` holds its value while `in_valid` stays low.
- R8: While `rst_n` is low, `out_valid` is 0.
- R9: Each lane's result depends only on its own index, the table, the length and its own fallback byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Captures the operands on this edge |
| in_desc | input | 8 | Descriptor; bits [1:0] hold the length code |
| in_table | input | 256 | Four 64-bit table words, word 0 in the low bits |
| in_index | input | 64 | Eight byte indices, one per lane |
| in_default | input | 64 | Fallback bytes for out-of-range lanes |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 64 | Assembled result word |

## Verification
The assertions check the following on every cycle:
- The valid strobe follows `in_valid` by exactly one cycle.
- The result stays stable when no new operands arrive.
- Every lane whose captured index is at or past the table length shows its fallback byte.
- The decoded length is always a nonzero multiple of eight, no larger than the table.
- The strobe is low during reset.

Only the bench's scenarios can show the following:
- Byte selection from the correct table word and byte position.
- Correct lane-to-bit mapping.
- The exact length boundary at each of the four length codes.
- That the upper descriptor bits and other lanes leave a result unchanged.

// File: rtl/tbl_lookup_pkg.sv
package tbl_lookup_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tbl_len_decode.sv
module tbl_len_decode
  import tbl_lookup_pkg::*;
#(
  parameter int CODE_W    = 2,
  parameter int LEN_W     = 9,
  parameter int TBL_BYTES = 32
) (
  input  logic [CODE_W-1:0] len_code,
  output logic [LEN_W-1:0]  len_bytes
);
  localparam int WORD_BYTES = 8;

  always_comb begin
    len_bytes = (LEN_W'(len_code) + LEN_W'(1)) * LEN_W'(WORD_BYTES);
  end

  // R1: decoded length is a whole number of table words within the table
  always_comb begin
    a_r1_len_legal: assert (len_bytes[2:0] == 3'd0 && len_bytes != '0 &&
                            int'(len_bytes) <= TBL_BYTES);
  end
endmodule

// File: rtl/tbl_lane.sv
module tbl_lane
  import tbl_lookup_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int LEN_W     = 9,
  parameter int TBL_BYTES = 32
) (
  input  logic [IDX_W-1:0]            idx,
  input  logic [LEN_W-1:0]            len_bytes,
  input  logic [TBL_BYTES*BYTE_W-1:0] tbl_flat,
  input  byte_t                       dflt_byte,
  output byte_t                       res_byte
);
  localparam int ADDR_W = $clog2(TBL_BYTES);

  byte_t             tbl_b [TBL_BYTES];
  logic              in_range;
  logic [ADDR_W-1:0] byte_addr;
  logic [IDX_W-ADDR_W-1:0] addr_hi_unused;

  for (genvar b = 0; b < TBL_BYTES; b++) begin : g_split
    assign tbl_b[b] = tbl_flat[b*BYTE_W +: BYTE_W];
  end

  assign byte_addr      = idx[ADDR_W-1:0];
  assign addr_hi_unused = idx[IDX_W-1:ADDR_W];

  always_comb begin
    in_range = (LEN_W'(idx) < len_bytes);
    res_byte = in_range ? tbl_b[byte_addr] : dflt_byte;
  end
endmodule

// File: rtl/tbl_lookup_unit.sv
module tbl_lookup_unit
  import tbl_lookup_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int IDX_W     = 8,
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 4,
  parameter int DESC_W    = 8,
  parameter int CODE_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [DESC_W-1:0]           in_desc,
  input  logic [NUM_WORDS*WORD_W-1:0] in_table,
  input  logic [LANES*IDX_W-1:0]      in_index,
  input  logic [LANES*BYTE_W-1:0]     in_default,
  output logic                        out_valid,
  output logic [LANES*BYTE_W-1:0]     out_result
);
  localparam int TBL_W     = NUM_WORDS * WORD_W;
  localparam int TBL_BYTES = TBL_W / BYTE_W;
  localparam int VEC_W     = LANES * BYTE_W;
  localparam int IVEC_W    = LANES * IDX_W;
  localparam int LEN_W     = IDX_W + 1;

  logic [CODE_W-1:0] code_q, code_d;
  logic [TBL_W-1:0]  tbl_q, tbl_d;
  logic [IVEC_W-1:0] idx_q, idx_d;
  logic [VEC_W-1:0]  dflt_q, dflt_d;
  logic              vld_q, vld_d;
  logic [LEN_W-1:0]  len_bytes;
  logic              desc_base_unused;

  assign desc_base_unused = ^in_desc[DESC_W-1:CODE_W];

  // next-state
  always_comb begin
    vld_d  = in_valid;
    code_d = code_q;
    tbl_d  = tbl_q;
    idx_d  = idx_q;
    dflt_d = dflt_q;
    if (in_valid) begin
      code_d = in_desc[CODE_W-1:0];
      tbl_d  = in_table;
      idx_d  = in_index;
      dflt_d = in_default;
    end
  end

  // control register with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // operand registers, enabled capture, no reset
  always_ff @(posedge clk) begin
    code_q <= code_d;
    tbl_q  <= tbl_d;
    idx_q  <= idx_d;
    dflt_q <= dflt_d;
  end

  tbl_len_decode #(
    .CODE_W   (CODE_W),
    .LEN_W    (LEN_W),
    .TBL_BYTES(TBL_BYTES)
  ) i_len (
    .len_code (code_q),
    .len_bytes(len_bytes)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tbl_lane #(
      .IDX_W    (IDX_W),
      .LEN_W    (LEN_W),
      .TBL_BYTES(TBL_BYTES)
    ) i_lane (
      .idx      (idx_q[k*IDX_W +: IDX_W]),
      .len_bytes(len_bytes),
      .tbl_flat (tbl_q),
      .dflt_byte(dflt_q[k*BYTE_W +: BYTE_W]),
      .res_byte (out_result[k*BYTE_W +: BYTE_W])
    );

    // R5: a lane whose index reaches the length shows its fallback byte
    a_r5_out_of_range_default: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && ((code_q + 3'd1) * 6'd8) <= {1'b0, idx_q[k*IDX_W +: IDX_W]})
        |-> out_result[k*BYTE_W +: BYTE_W] == dflt_q[k*BYTE_W +: BYTE_W]);
  end

  assign out_valid = vld_q;

  // R7: strobe follows the capture by exactly one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7: result holds without new operands
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

  // R8: strobe low while reset is held
  always @(posedge clk) begin
    if (!rst_n) a_r8_reset_clears_valid: assert (!out_valid);
  end
endmodule

// File: tb/test_tbl_lookup_unit.sv
module test_tbl_lookup_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } sb_item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [7:0]   in_desc;
  logic [255:0] in_table;
  logic [63:0]  in_index;
  logic [63:0]  in_default;
  logic         out_valid;
  logic [63:0]  out_result;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  sb_item_t sb_q[$];

  tbl_lookup_unit i_tbl_lookup_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_desc(in_desc),
    .in_table(in_table), .in_index(in_index), .in_default(in_default),
    .out_valid(out_valid), .out_result(out_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model(logic [7:0] d, logic [255:0] t,
                                        logic [63:0] ix, logic [63:0] df);
    logic [63:0] r;
    int len;
    len = (int'(d[1:0]) + 1) * 8;
    for (int k = 0; k < 8; k++) begin
      int i;
      i = int'(ix[8*k +: 8]);
      if (i < len) r[8*k +: 8] = t[64*(i / 8) + 8*(i % 8) +: 8];
      else         r[8*k +: 8] = df[8*k +: 8];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: presents one operand set at a falling edge, scoreboards expectation
  task automatic drive(string tag, logic [7:0] d, logic [63:0] ix);
    sb_item_t it;
    @(negedge clk);
    in_desc  = d;
    in_index = ix;
    in_valid = 1'b1;
    it.exp = model(d, in_table, ix, in_default);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (sb_q.size() == 0) check("R7 unexpected valid", 64'd1, 64'd0);
      else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(it.tag, out_result, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_desc = '0;
    in_index = '0;
    for (int b = 0; b < 32; b++) in_table[8*b +: 8] = 8'(b * 7 + 3);
    for (int b = 0; b < 8; b++)  in_default[8*b +: 8] = 8'(8'hD0 + b);
    repeat (3) @(negedge clk);
    check("R8 reset valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 valid after release", 64'(out_valid), 64'd0);

    drive("R2 R4 identity lanes n=0", 8'h00, 64'h07060504_03020100);
    drive("R3 boundary 8 at n=0", 8'h00, 64'h08070800_09FF0708);
    drive("R1 R4 n=3 word picks", 8'h03, 64'h1F18100F_08171E01);
    drive("R3 boundary n=1", 8'h01, 64'h0F100F10_0E11000F);
    drive("R3 boundary n=2", 8'h02, 64'h17181718_16191F20);
    drive("R5 all out of range", 8'h00, 64'hFFC08040_201A0908);
    drive("R6 upper bits set n=1", 8'hFD, 64'h0F100F10_0E11000F);
    drive("R6 upper bits set n=3", 8'hAB, 64'h1F201F20_00FF1011);
    drive("R9 single lane varied", 8'h02, 64'h00000000_00000000);
    drive("R9 single lane varied b", 8'h02, 64'h00000000_00170000);
    idle();
    @(negedge clk);
    check("R7 no valid when idle", 64'(out_valid), 64'd0);
    held = out_result;
    @(negedge clk);
    check("R7 result held", out_result, held);
    in_table[255:192] = 64'h0123_4567_89AB_CDEF;
    drive("R4 word 3 update", 8'h03, 64'h18191A1B_1C1D1E1F);
    drive("R4 word 3 out of n=2", 8'h02, 64'h18191A1B_1C1D1E1F);
    idle();
    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 64'(sb_q.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule